// File: doc/BRIEF.md
# Prioritized Interrupt Dispatcher

This block sits beside a processor's sequencer and decides, at each instruction boundary the sequencer offers, which interruption class to take. It holds the processor's current status word (a 64-bit mask and a 64-bit address), records one synchronous exception (program fault or supervisor call), and keeps pending state for the asynchronous sources: a machine-check queue count, an external-event queue count, clock-comparator and CPU-timer event flags, and one queue count per I/O subclass. Control-register inputs supply the I/O subclass mask and the machine-check enable.

When the sequencer pulses `take_i`, the block arbitrates and, if a class wins, presents the class, the interruption code and the old status-word image with the live condition code merged in. In the following cycle the surrounding logic presents the new status word for that class on `new_mask_i`/`new_addr_i`, and the block loads it, raising `halted_o` when the new word waits with every interruption class disabled. Writing the save areas to memory and decoding instruction lengths are left to other logic.

The control is a three-state machine: `ST_IDLE` (waits; `take_i` moves to `ST_ARB`, `psw_wr_i` loads a status word), `ST_ARB` (one cycle of arbitration; a winner moves to `ST_LOAD`, no winner returns to `ST_IDLE`), and `ST_LOAD` (one cycle with the dispatch visible; always returns to `ST_IDLE` after loading the new word).

Top module: `irq_dispatch`

## Requirements
- R1: A recorded exception (set by `exc_set_i`) wins every arbitration: class 1 for a supervisor call, class 0 for a program fault, with code `exc_code_i`; asynchronous classes are looked at only when no exception is recorded, and the record clears when taken.
- R2: Among asynchronous classes the order is machine check (class 4), then external (class 2), then I/O (class 3); each is considered only when its enable bit of the current mask is set: bit 50 machine check, bit 56 external, bit 57 I/O.
- R3: Inside the external class a queued external event wins and delivers `ext_code_i`; otherwise a clock-comparator event delivers code 0x1004; otherwise a CPU-timer event delivers code 0x1005.
- R4: A selected machine check is delivered only when bit 28 of `cr14_i` is set; otherwise that arbitration delivers nothing, lower classes are not taken, and the machine check stays pending.
- R5: I/O subclasses are scanned from 0 upward; a subclass is eligible only with a nonzero count and its bit of `cr6_i` set; the first eligible one is delivered with its subclass number as the code; with none eligible nothing is delivered.
- R6: A delivery lowers the chosen queue count by one (or clears the chosen timer flag); a queued class stays pending while its count is nonzero, and I/O stays pending while any subclass count is nonzero, masked or not.
- R7: The old image equals the current mask with bits 45:44 replaced by `cc_i`; `cc_o` is bits 45:44 of the loaded mask.
- R8: For a supervisor call the old address is the current address plus `exc_ilen_i` (2, 4 or 6); for all other classes it is the current address.
- R9: A loaded word (by dispatch or by `psw_wr_i`) with bit 49 set and bits 57, 56 and 50 clear sets `halted_o`; any other loaded word clears it.
- R10: `irq_o` is high exactly while any asynchronous source is pending.
- R11: Events arriving in the arbitration cycle are kept: a push and a pop on the same count cancel, and a timer event setting the flag that is being taken leaves it set.
- R12: `take_i` seen in `ST_IDLE` gives arbitration in the next cycle, `dsp_valid_o` high for exactly the cycle after that, and the new word loaded at its end; `take_i` and `psw_wr_i` outside `ST_IDLE` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | Instruction-boundary request to arbitrate |
| exc_set_i | input | 1 | Record a synchronous exception |
| exc_svc_i | input | 1 | Recorded exception is a supervisor call |
| exc_code_i | input | 16 | Code of the recorded exception |
| exc_ilen_i | input | 3 | Instruction length of the recorded exception |
| ext_push_i | input | 1 | Queue one external event |
| ext_code_i | input | 16 | Code delivered for a queued external event |
| ckc_evt_i | input | 1 | Clock-comparator event |
| cpt_evt_i | input | 1 | CPU-timer event |
| mchk_push_i | input | 1 | Queue one machine check |
| io_push_i | input | 1 | Queue one I/O entry |
| io_sub_i | input | SUBW | Subclass of the queued I/O entry |
| cr6_i | input | NSUB | I/O subclass mask |
| cr14_i | input | 32 | Control word holding the machine-check enable |
| cc_i | input | 2 | Live condition code |
| psw_wr_i | input | 1 | Load a status word directly |
| psw_wr_mask_i | input | 64 | Mask for a direct load |
| psw_wr_addr_i | input | 64 | Address for a direct load |
| new_mask_i | input | 64 | New mask for the class being dispatched |
| new_addr_i | input | 64 | New address for the class being dispatched |
| irq_o | output | 1 | Asynchronous work pending |
| dsp_valid_o | output | 1 | Dispatch outputs valid this cycle |
| dsp_class_o | output | 3 | Class taken |
| dsp_code_o | output | 16 | Interruption code |
| old_mask_o | output | 64 | Old mask image with condition code |
| old_addr_o | output | 64 | Old address image |
| psw_mask_o | output | 64 | Current mask |
| psw_addr_o | output | 64 | Current address |
| cc_o | output | 2 | Condition code of the current mask |
| halted_o | output | 1 | Processor halted by a waiting word |

## Verification
The two functions that share a cycle are arbitration-time consumption of a source and the arrival of a new event for that same source: while `ST_ARB` pops a queue or clears a timer flag, the bench pushes a new entry into that queue or fires that timer in the very same cycle. It then judges by arbitrating again: the source must be delivered a second time and `irq_o` must stay high until that second delivery. A behavioural reference model, stepped on every clock, also compares every output each cycle so a lost or doubled event shows up at once.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
    typedef enum logic [2:0] {
        CLS_PGM  = 3'd0,
        CLS_SVC  = 3'd1,
        CLS_EXT  = 3'd2,
        CLS_IO   = 3'd3,
        CLS_MCHK = 3'd4,
        CLS_NONE = 3'd7
    } cls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_LOAD = 2'd2
    } st_e;

    localparam int MB_IO_EN   = 57;
    localparam int MB_EXT_EN  = 56;
    localparam int MB_MCHK_EN = 50;
    localparam int MB_WAIT    = 49;
    localparam int MB_CC_LO   = 44;
    localparam int CR14_MCE   = 28;

    localparam logic [15:0] CODE_CLKCMP = 16'h1004;
    localparam logic [15:0] CODE_CPUTMR = 16'h1005;

    function automatic logic halts(input logic [63:0] m);
        return m[MB_WAIT] & ~(m[MB_IO_EN] | m[MB_EXT_EN] | m[MB_MCHK_EN]);
    endfunction
endpackage

// File: rtl/dsp_qcount.sv
module dsp_qcount #(
    parameter int DEPTH = 15,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case ({push, pop})
                2'b10:   if (cnt != CW'(DEPTH)) cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end

    // R6: a delivery never takes from an empty queue
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> cnt != '0);
    // R6: a lone delivery lowers the count by exactly one
    assert_pop_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> cnt == $past(cnt) - 1'b1);
    // R11: push and pop in one cycle cancel
    assert_push_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && push) |=> $stable(cnt));
endmodule

// File: rtl/dsp_pending.sv
module dsp_pending #(
    parameter int NSUB  = 8,
    parameter int DEPTH = 15,
    localparam int SUBW = $clog2(NSUB),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mchk_push,
    input  logic            mchk_pop,
    input  logic            ext_push,
    input  logic            ext_pop,
    input  logic            ckc_set,
    input  logic            ckc_clr,
    input  logic            cpt_set,
    input  logic            cpt_clr,
    input  logic            io_push,
    input  logic [SUBW-1:0] io_sub,
    input  logic [NSUB-1:0] io_pop,
    output logic            mchk_pend,
    output logic            ext_pend,
    output logic            ckc_pend,
    output logic            cpt_pend,
    output logic [NSUB-1:0] io_nz,
    output logic            irq
);
    logic [CW-1:0] mchk_cnt;
    logic [CW-1:0] ext_cnt;

    dsp_qcount #(.DEPTH(DEPTH)) u_mchk_q (
        .clk(clk), .rst_n(rst_n), .push(mchk_push), .pop(mchk_pop), .cnt(mchk_cnt));
    dsp_qcount #(.DEPTH(DEPTH)) u_ext_q (
        .clk(clk), .rst_n(rst_n), .push(ext_push), .pop(ext_pop), .cnt(ext_cnt));

    for (genvar g = 0; g < NSUB; g++) begin : g_io
        logic [CW-1:0] sub_cnt;
        dsp_qcount #(.DEPTH(DEPTH)) u_io_q (
            .clk(clk), .rst_n(rst_n),
            .push(io_push && (io_sub == SUBW'(g))),
            .pop(io_pop[g]), .cnt(sub_cnt));
        assign io_nz[g] = (sub_cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ckc_pend <= 1'b0;
            cpt_pend <= 1'b0;
        end else begin
            if (ckc_set)      ckc_pend <= 1'b1;
            else if (ckc_clr) ckc_pend <= 1'b0;
            if (cpt_set)      cpt_pend <= 1'b1;
            else if (cpt_clr) cpt_pend <= 1'b0;
        end
    end

    assign mchk_pend = (mchk_cnt != '0);
    assign ext_pend  = (ext_cnt != '0);
    assign irq       = mchk_pend | ext_pend | ckc_pend | cpt_pend | (|io_nz);

    // R11: a timer event landing on the cycle its flag is taken survives
    assert_ckc_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ckc_set |=> ckc_pend);
    assert_cpt_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpt_set |=> cpt_pend);
endmodule

// File: rtl/dsp_arbiter.sv
module dsp_arbiter
    import dsp_pkg::*;
#(
    parameter int NSUB = 8
) (
    input  logic            exc_vld,
    input  logic            exc_svc,
    input  logic [15:0]     exc_code,
    input  logic [63:0]     cur_mask,
    input  logic            mchk_pend,
    input  logic            ext_pend,
    input  logic            ckc_pend,
    input  logic            cpt_pend,
    input  logic [NSUB-1:0] io_nz,
    input  logic [NSUB-1:0] cr6,
    input  logic [31:0]     cr14,
    input  logic [15:0]     ext_code,
    output logic            win,
    output cls_e            cls,
    output logic [15:0]     code,
    output logic            pop_exc,
    output logic            pop_mchk,
    output logic            pop_ext,
    output logic            pop_ckc,
    output logic            pop_cpt,
    output logic [NSUB-1:0] pop_io
);
    logic io_found;

    always_comb begin
        win      = 1'b0;
        cls      = CLS_NONE;
        code     = 16'h0000;
        pop_exc  = 1'b0;
        pop_mchk = 1'b0;
        pop_ext  = 1'b0;
        pop_ckc  = 1'b0;
        pop_cpt  = 1'b0;
        pop_io   = '0;
        io_found = 1'b0;
        if (exc_vld) begin
            win     = 1'b1;
            cls     = exc_svc ? CLS_SVC : CLS_PGM;
            code    = exc_code;
            pop_exc = 1'b1;
        end else if (cur_mask[MB_MCHK_EN] && mchk_pend) begin
            if (cr14[CR14_MCE]) begin
                win      = 1'b1;
                cls      = CLS_MCHK;
                pop_mchk = 1'b1;
            end
        end else if (cur_mask[MB_EXT_EN] && (ext_pend || ckc_pend || cpt_pend)) begin
            win = 1'b1;
            cls = CLS_EXT;
            if (ext_pend) begin
                code    = ext_code;
                pop_ext = 1'b1;
            end else if (ckc_pend) begin
                code    = CODE_CLKCMP;
                pop_ckc = 1'b1;
            end else begin
                code    = CODE_CPUTMR;
                pop_cpt = 1'b1;
            end
        end else if (cur_mask[MB_IO_EN] && (|io_nz)) begin
            for (int s = 0; s < NSUB; s++) begin
                if (!io_found && io_nz[s] && cr6[s]) begin
                    io_found  = 1'b1;
                    win       = 1'b1;
                    cls       = CLS_IO;
                    code      = 16'(s);
                    pop_io[s] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import dsp_pkg::*;
#(
    parameter int NSUB  = 8,
    parameter int DEPTH = 15,
    localparam int SUBW = $clog2(NSUB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic            exc_set_i,
    input  logic            exc_svc_i,
    input  logic [15:0]     exc_code_i,
    input  logic [2:0]      exc_ilen_i,
    input  logic            ext_push_i,
    input  logic [15:0]     ext_code_i,
    input  logic            ckc_evt_i,
    input  logic            cpt_evt_i,
    input  logic            mchk_push_i,
    input  logic            io_push_i,
    input  logic [SUBW-1:0] io_sub_i,
    input  logic [NSUB-1:0] cr6_i,
    input  logic [31:0]     cr14_i,
    input  logic [1:0]      cc_i,
    input  logic            psw_wr_i,
    input  logic [63:0]     psw_wr_mask_i,
    input  logic [63:0]     psw_wr_addr_i,
    input  logic [63:0]     new_mask_i,
    input  logic [63:0]     new_addr_i,
    output logic            irq_o,
    output logic            dsp_valid_o,
    output logic [2:0]      dsp_class_o,
    output logic [15:0]     dsp_code_o,
    output logic [63:0]     old_mask_o,
    output logic [63:0]     old_addr_o,
    output logic [63:0]     psw_mask_o,
    output logic [63:0]     psw_addr_o,
    output logic [1:0]      cc_o,
    output logic            halted_o
);
    localparam logic [63:0] CC_FIELD = 64'h3 << MB_CC_LO;

    st_e state, state_nx;

    logic        exc_rec, exc_svc_q;
    logic [15:0] exc_code_q;
    logic [2:0]  exc_ilen_q;

    logic            mchk_pend, ext_pend, ckc_pend, cpt_pend;
    logic [NSUB-1:0] io_nz;
    logic            sel_win;
    cls_e            sel_cls;
    logic [15:0]     sel_code;
    logic            pop_exc, pop_mchk, pop_ext, pop_ckc, pop_cpt;
    logic [NSUB-1:0] pop_io;

    logic            do_arb, do_disp, do_load, do_wr;

    dsp_pending #(.NSUB(NSUB), .DEPTH(DEPTH)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .mchk_push(mchk_push_i), .mchk_pop(pop_mchk && do_disp),
        .ext_push(ext_push_i),   .ext_pop(pop_ext && do_disp),
        .ckc_set(ckc_evt_i),     .ckc_clr(pop_ckc && do_disp),
        .cpt_set(cpt_evt_i),     .cpt_clr(pop_cpt && do_disp),
        .io_push(io_push_i),     .io_sub(io_sub_i),
        .io_pop(pop_io & {NSUB{do_disp}}),
        .mchk_pend(mchk_pend), .ext_pend(ext_pend),
        .ckc_pend(ckc_pend), .cpt_pend(cpt_pend),
        .io_nz(io_nz), .irq(irq_o));

    dsp_arbiter #(.NSUB(NSUB)) u_arb (
        .exc_vld(exc_rec), .exc_svc(exc_svc_q), .exc_code(exc_code_q),
        .cur_mask(psw_mask_o),
        .mchk_pend(mchk_pend), .ext_pend(ext_pend),
        .ckc_pend(ckc_pend), .cpt_pend(cpt_pend),
        .io_nz(io_nz), .cr6(cr6_i), .cr14(cr14_i), .ext_code(ext_code_i),
        .win(sel_win), .cls(sel_cls), .code(sel_code),
        .pop_exc(pop_exc), .pop_mchk(pop_mchk), .pop_ext(pop_ext),
        .pop_ckc(pop_ckc), .pop_cpt(pop_cpt), .pop_io(pop_io));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and per-state controls
    always_comb begin
        state_nx = state;
        do_arb   = 1'b0;
        do_disp  = 1'b0;
        do_load  = 1'b0;
        do_wr    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                do_wr = psw_wr_i;
                if (take_i) state_nx = ST_ARB;
            end
            ST_ARB: begin
                do_arb   = 1'b1;
                do_disp  = sel_win;
                state_nx = sel_win ? ST_LOAD : ST_IDLE;
            end
            ST_LOAD: begin
                do_load  = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign dsp_valid_o = (state == ST_LOAD);
    assign cc_o        = psw_mask_o[MB_CC_LO +: 2];

    // exception record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exc_rec    <= 1'b0;
            exc_svc_q  <= 1'b0;
            exc_code_q <= '0;
            exc_ilen_q <= '0;
        end else if (exc_set_i) begin
            exc_rec    <= 1'b1;
            exc_svc_q  <= exc_svc_i;
            exc_code_q <= exc_code_i;
            exc_ilen_q <= exc_ilen_i;
        end else if (do_disp && pop_exc) begin
            exc_rec <= 1'b0;
        end
    end

    // dispatch image and status word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dsp_class_o <= CLS_NONE;
            dsp_code_o  <= '0;
            old_mask_o  <= '0;
            old_addr_o  <= '0;
            psw_mask_o  <= '0;
            psw_addr_o  <= '0;
            halted_o    <= 1'b0;
        end else begin
            if (do_disp) begin
                dsp_class_o <= sel_cls;
                dsp_code_o  <= sel_code;
                old_mask_o  <= (psw_mask_o & ~CC_FIELD) | (64'(cc_i) << MB_CC_LO);
                old_addr_o  <= (sel_cls == CLS_SVC) ? psw_addr_o + 64'(exc_ilen_q)
                                                    : psw_addr_o;
            end
            if (do_load) begin
                psw_mask_o <= new_mask_i;
                psw_addr_o <= new_addr_i;
                halted_o   <= halts(new_mask_i);
            end else if (do_wr) begin
                psw_mask_o <= psw_wr_mask_i;
                psw_addr_o <= psw_wr_addr_i;
                halted_o   <= halts(psw_wr_mask_i);
            end
        end
    end

    // R12: a dispatch is visible for exactly one cycle
    assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid_o |=> !dsp_valid_o);
    // R1: a recorded exception always produces a synchronous class
    assert_exc_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (do_arb && exc_rec) |=> dsp_valid_o &&
            (dsp_class_o == CLS_SVC || dsp_class_o == CLS_PGM));
    // R7: the old image carries the live condition code
    assert_cc_merge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        do_disp |=> old_mask_o[MB_CC_LO +: 2] == $past(cc_i));
    // R9: after a load the halt flag follows the loaded word
    assert_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (do_load || do_wr) |=> halted_o == (psw_mask_o[MB_WAIT] &&
            !psw_mask_o[MB_IO_EN] && !psw_mask_o[MB_EXT_EN] && !psw_mask_o[MB_MCHK_EN]));
    // R5: at most one subclass is taken per arbitration
    assert_one_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop_io));
    // R8: recorded supervisor-call lengths are 2, 4 or 6
    assert_ilen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_rec && exc_svc_q) |-> (exc_ilen_q == 3'd2 || exc_ilen_q == 3'd4 ||
                                    exc_ilen_q == 3'd6));
endmodule

// File: tb/irq_dispatch_tb.sv
module irq_dispatch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSUB  = 8;
    localparam int DEPTH = 15;
    localparam logic [63:0] EN_ALL = 64'h0304_0000_0000_0000;
    localparam logic [63:0] EN_IOM = 64'h0204_0000_0000_0000;
    localparam logic [63:0] WAITB  = 64'h0002_0000_0000_0000;
    localparam logic [63:0] CC2    = 64'h0000_2000_0000_0000;
    localparam logic [63:0] CC1    = 64'h0000_1000_0000_0000;

    logic clk = 0, rst_n = 0;
    logic take_i = 0, exc_set_i = 0, exc_svc_i = 0;
    logic [15:0] exc_code_i = 0, ext_code_i = 0;
    logic [2:0] exc_ilen_i = 0;
    logic ext_push_i = 0, ckc_evt_i = 0, cpt_evt_i = 0, mchk_push_i = 0, io_push_i = 0;
    logic [2:0] io_sub_i = 0;
    logic [7:0] cr6_i = 8'hFF;
    logic [31:0] cr14_i = 32'h1000_0000;
    logic [1:0] cc_i = 0;
    logic psw_wr_i = 0;
    logic [63:0] psw_wr_mask_i = 0, psw_wr_addr_i = 0, new_mask_i = 0, new_addr_i = 0;
    logic irq_o, dsp_valid_o, halted_o;
    logic [2:0] dsp_class_o;
    logic [15:0] dsp_code_o;
    logic [63:0] old_mask_o, old_addr_o, psw_mask_o, psw_addr_o;
    logic [1:0] cc_o;

    int n_cmp = 0, n_bad = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_dispatch #(.NSUB(NSUB), .DEPTH(DEPTH)) u_dut (.*);

    // behavioural reference model
    int m_phase, m_ext, m_mchk;
    int m_io[NSUB];
    bit m_ckc, m_cpt, m_exc, m_svc, m_halt, m_valid;
    int m_ilen;
    logic [15:0] m_ecode, m_code;
    logic [63:0] m_mask, m_addr, m_omask, m_oaddr;
    int m_cls;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_ext = 0; m_mchk = 0; m_ckc = 0; m_cpt = 0; m_exc = 0;
            m_svc = 0; m_halt = 0; m_valid = 0; m_ilen = 0; m_ecode = 0;
            m_mask = 0; m_addr = 0;
            foreach (m_io[i]) m_io[i] = 0;
        end else begin
            int nph;
            int got;
            nph = 0; got = -1;
            if (m_phase == 0) begin
                if (psw_wr_i) begin
                    m_mask = psw_wr_mask_i; m_addr = psw_wr_addr_i;
                    m_halt = m_mask[49] && !m_mask[57] && !m_mask[56] && !m_mask[50];
                end
                nph = take_i ? 1 : 0;
            end else if (m_phase == 1) begin
                bit anyio;
                anyio = 0;
                foreach (m_io[i]) if (m_io[i] > 0) anyio = 1;
                if (m_exc) begin
                    got = m_svc ? 1 : 0; m_code = m_ecode; m_exc = 0;
                end else if (m_mask[50] && m_mchk > 0) begin
                    if (cr14_i[28]) begin got = 4; m_code = 0; m_mchk--; end
                end else if (m_mask[56] && (m_ext > 0 || m_ckc || m_cpt)) begin
                    got = 2;
                    if (m_ext > 0) begin m_code = ext_code_i; m_ext--; end
                    else if (m_ckc) begin m_code = 16'h1004; m_ckc = 0; end
                    else begin m_code = 16'h1005; m_cpt = 0; end
                end else if (m_mask[57] && anyio) begin
                    for (int s = 0; s < NSUB; s++)
                        if (got < 0 && m_io[s] > 0 && cr6_i[s]) begin
                            got = 3; m_code = 16'(s); m_io[s]--;
                        end
                end
                if (got >= 0) begin
                    m_cls = got;
                    m_omask = m_mask; m_omask[45:44] = cc_i;
                    m_oaddr = (got == 1) ? m_addr + 64'(m_ilen) : m_addr;
                    nph = 2;
                end
            end else begin
                m_mask = new_mask_i; m_addr = new_addr_i;
                m_halt = m_mask[49] && !m_mask[57] && !m_mask[56] && !m_mask[50];
            end
            if (ext_push_i && m_ext < DEPTH) m_ext++;
            if (mchk_push_i && m_mchk < DEPTH) m_mchk++;
            if (io_push_i && m_io[io_sub_i] < DEPTH) m_io[io_sub_i]++;
            if (ckc_evt_i) m_ckc = 1;
            if (cpt_evt_i) m_cpt = 1;
            if (exc_set_i) begin
                m_exc = 1; m_svc = exc_svc_i; m_ecode = exc_code_i; m_ilen = exc_ilen_i;
            end
            m_phase = nph;
            m_valid = (nph == 2);
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit any_pend();
        bit a;
        a = (m_ext > 0) || (m_mchk > 0) || m_ckc || m_cpt;
        foreach (m_io[i]) if (m_io[i] > 0) a = 1;
        return a;
    endfunction

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R10 irq_o", 64'(irq_o), 64'(any_pend()));
            chk("R12 dsp_valid_o", 64'(dsp_valid_o), 64'(m_valid));
            chk("R12 psw_mask_o", psw_mask_o, m_mask);
            chk("R8 psw_addr_o", psw_addr_o, m_addr);
            chk("R7 cc_o", 64'(cc_o), 64'(m_mask[45:44]));
            chk("R9 halted_o", 64'(halted_o), 64'(m_halt));
            if (m_valid) begin
                chk("R2 dsp_class_o", 64'(dsp_class_o), 64'(m_cls));
                chk("R3 dsp_code_o", 64'(dsp_code_o), 64'(m_code));
                chk("R7 old_mask_o", old_mask_o, m_omask);
                chk("R8 old_addr_o", old_addr_o, m_oaddr);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic cyc(); @(negedge clk); endtask

    task automatic pulse_ext(input logic [15:0] c);
        ext_push_i = 1; ext_code_i = c; cyc(); ext_push_i = 0;
    endtask
    task automatic pulse_ckc(); ckc_evt_i = 1; cyc(); ckc_evt_i = 0; endtask
    task automatic pulse_cpt(); cpt_evt_i = 1; cyc(); cpt_evt_i = 0; endtask
    task automatic pulse_mchk(); mchk_push_i = 1; cyc(); mchk_push_i = 0; endtask
    task automatic pulse_io(input logic [2:0] s);
        io_push_i = 1; io_sub_i = s; cyc(); io_push_i = 0;
    endtask
    task automatic wr_psw(input logic [63:0] m, input logic [63:0] a);
        psw_wr_i = 1; psw_wr_mask_i = m; psw_wr_addr_i = a; cyc(); psw_wr_i = 0;
    endtask

    // take once; arb_ckc / arb_io inject an event during the arbitration cycle
    task automatic take_once(input bit ev, input logic [2:0] ec, input logic [15:0] ecode,
                             input string tag, input bit arb_ckc = 0, input bit arb_io = 0);
        take_i = 1; cyc(); take_i = 0;
        ckc_evt_i = arb_ckc; io_push_i = arb_io;
        cyc();
        ckc_evt_i = 0; io_push_i = 0;
        chk({tag, " valid"}, 64'(dsp_valid_o), 64'(ev));
        if (ev) begin
            chk({tag, " class"}, 64'(dsp_class_o), 64'(ec));
            chk({tag, " code"}, 64'(dsp_code_o), 64'(ecode));
        end
        cyc();
    endtask

    initial begin
        repeat (3) cyc();
        // reset state (R10, R12)
        chk("R10 reset irq", 64'(irq_o), 0);
        chk("R12 reset valid", 64'(dsp_valid_o), 0);
        chk("R9 reset halted", 64'(halted_o), 0);
        rst_n = 1;
        cyc();
        wr_psw(EN_ALL | CC2, 64'h1000);
        chk("R7 cc after write", 64'(cc_o), 2);
        new_mask_i = EN_ALL | CC1; new_addr_i = 64'h2000;
        // all classes pending: R2 order, R3 external sub-order
        pulse_io(3); pulse_io(1); pulse_ext(16'h2222); pulse_ckc(); pulse_mchk();
        take_once(1, 3'd4, 16'h0, "R2 mchk first");
        take_once(1, 3'd2, 16'h2222, "R3 queued external");
        take_once(1, 3'd2, 16'h1004, "R3 clock comparator");
        pulse_cpt();
        take_once(1, 3'd2, 16'h1005, "R3 cpu timer");
        // R5 subclass scan and mask
        take_once(1, 3'd3, 16'd1, "R5 lowest subclass");
        cr6_i = 8'hF7;
        take_once(0, 3'd0, 16'h0, "R5 masked subclass");
        chk("R6 io still pending", 64'(irq_o), 1);
        cr6_i = 8'hFF;
        take_once(1, 3'd3, 16'd3, "R5 unmasked subclass");
        chk("R6 io drained", 64'(irq_o), 0);
        // R1 exception before asynchronous, R8 supervisor-call address
        pulse_ext(16'h3333);
        cc_i = 2'd3;
        exc_set_i = 1; exc_svc_i = 1; exc_code_i = 16'h0012; exc_ilen_i = 3'd4; cyc();
        exc_set_i = 0;
        take_once(1, 3'd1, 16'h0012, "R1 supervisor call first");
        chk("R8 svc old address", old_addr_o, 64'h2004);
        chk("R7 old cc", 64'(old_mask_o[45:44]), 3);
        take_once(1, 3'd2, 16'h3333, "R1 external after exception");
        exc_set_i = 1; exc_svc_i = 0; exc_code_i = 16'h0004; exc_ilen_i = 3'd6; cyc();
        exc_set_i = 0;
        take_once(1, 3'd0, 16'h0004, "R1 program fault");
        chk("R8 program old address", old_addr_o, 64'h2000);
        // R4 machine-check enable
        cr14_i = 32'h0; pulse_mchk(); pulse_ckc();
        take_once(0, 3'd0, 16'h0, "R4 mchk blocked");
        chk("R4 still pending", 64'(irq_o), 1);
        cr14_i = 32'h1000_0000;
        take_once(1, 3'd4, 16'h0, "R4 mchk enabled");
        take_once(1, 3'd2, 16'h1004, "R4 external after mchk");
        // R2 enable gating
        wr_psw(EN_IOM, 64'h3000);
        new_mask_i = EN_IOM;
        pulse_ckc(); pulse_io(5);
        take_once(1, 3'd3, 16'd5, "R2 external disabled");
        wr_psw(EN_ALL, 64'h3000);
        new_mask_i = EN_ALL;
        take_once(1, 3'd2, 16'h1004, "R2 external enabled");
        // R11 events in the arbitration cycle
        pulse_ckc();
        take_once(1, 3'd2, 16'h1004, "R11 ckc taken", 1, 0);
        chk("R11 ckc kept", 64'(irq_o), 1);
        take_once(1, 3'd2, 16'h1004, "R11 ckc again");
        pulse_io(2);
        io_sub_i = 3'd2;
        take_once(1, 3'd3, 16'd2, "R11 io taken", 0, 1);
        take_once(1, 3'd3, 16'd2, "R11 io again");
        take_once(0, 3'd0, 16'h0, "R11 nothing left");
        // R12 take ignored outside idle
        pulse_ext(16'h4444); pulse_ext(16'h4444);
        take_i = 1; cyc(); cyc(); take_i = 0; cyc(); cyc();
        chk("R12 one dispatch only", 64'(irq_o), 1);
        take_once(1, 3'd2, 16'h4444, "R12 remaining entry");
        chk("R12 drained", 64'(irq_o), 0);
        // R9 halt on a waiting word
        new_mask_i = WAITB;
        pulse_cpt();
        take_once(1, 3'd2, 16'h1005, "R9 dispatch to wait");
        chk("R9 halted", 64'(halted_o), 1);
        wr_psw(EN_ALL | WAITB, 64'h5000);
        chk("R9 halt released", 64'(halted_o), 0);
        repeat (4) cyc();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule